// File: doc/BRIEF.md
# SMI Event Status Register

This block collects the system-management events of a platform controller into one write-one-to-clear status word and drives an active-low SMI request while any of them is pending. Each event has its own set rule. A flash write is flagged as a protection violation. A protect-enable is flagged when it is switched on while its lock-down bit holds. A BCD year value rolls over from 99 to 00. The watchdog expires. Software writes either of two mailbox ports. An NMI-class event arrives while redirection to SMI is enabled.

The century flag is kept in a slow real-time-clock domain and has its own asynchronous reset there. Its clear request is carried into that domain by a toggle synchronizer. Its level is brought back into the fast domain through a synchronizer chain, so a cleared bit reads 1 until the slow side has really dropped it. The NMI-redirect bit follows the NMI source and cannot be written.

Top module: `smi_evt_status`

## Requirements
- R1: Writing 1 to status bit 8, 3, 2 or 1 on `reg_wr` clears that bit in the next cycle. Writing 0 to a bit leaves it unchanged.
- R2: When a set event and a write-1 clear reach the same bit in the same cycle, the bit is 1 afterwards.
- R3: A `flash_wr` pulse sets bit 8 only when `prot_en` is 1 and `flash_low_alias` is 0.
- R4: A change of `prot_en` from 0 to 1 sets bit 8 when `prot_lock` is 1, and does not set it when `prot_lock` is 0. Holding `prot_en` at 1 sets nothing further.
- R5: Bit 7 sets when `year_bcd`, sampled on `rtc_clk`, goes from 8'h99 to 8'h00. No other transition in a full BCD sweep from 00 to 99 sets it.
- R6: After a write of 1 to bit 7, the bit still reads 1 in the cycle that follows the write. It reads 0 once three `rtc_clk` edges and two `clk` edges have passed.
- R7: Asserting `rtc_rst_n` low clears bit 7.
- R8: A pulse on `wdog_expire` sets bit 3. A pulse on `hnd_out_wr` sets bit 2. A pulse on `sw_in_wr` sets bit 1.
- R9: Bit 0 sets when `nmi_pending` is 1 while `nmi_redir_en` is 1. It stays 1 while `nmi_pending` stays 1, even if the enable drops. Writes to bit 0 are ignored. It clears the cycle after `nmi_pending` goes to 0.
- R10: Bits 6:4 always read 0, and writes to them change nothing.
- R11: `smi_req_n` is 0 while any status bit is 1 and 1 when all are 0.
- R12: After reset, `status` is 0 and `smi_req_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Fast-domain asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 9 | Write data, a 1 clears the matching bit |
| prot_en | input | 1 | Flash write-protect enable |
| prot_lock | input | 1 | Lock-down of the protect enable |
| flash_wr | input | 1 | Decoded flash write pulse |
| flash_low_alias | input | 1 | Flash write targets the lower alias range |
| rtc_clk | input | 1 | Slow real-time-clock domain clock |
| rtc_rst_n | input | 1 | Slow-domain asynchronous reset, active low |
| year_bcd | input | 8 | BCD year value, synchronous to rtc_clk |
| wdog_expire | input | 1 | Watchdog reached zero, one-cycle pulse |
| hnd_out_wr | input | 1 | Handler wrote the data-out mailbox |
| sw_in_wr | input | 1 | Software wrote the data-in mailbox |
| nmi_redir_en | input | 1 | Redirect NMI-class events to SMI |
| nmi_pending | input | 1 | Underlying NMI status level |
| status | output | 9 | Status word |
| smi_req_n | output | 1 | SMI request, active low |

## Verification
The century clear is the hardest case to reach, because it crosses two domains in both directions. It can only be seen as the bit still reading 1 just after the write and as 0 a few slow periods later. The bench first sweeps the BCD year through every value from 00 to 99 on the slow clock, which must leave the bit clear. A final step to 00 then sets the bit. The bench checks the cycle right after the clear write, then waits long enough for both synchronizer paths before checking again. A slow-domain reset then repeats the clearing by the other route.

// File: rtl/smi_stat_pkg.sv
package smi_stat_pkg;
   localparam int STAT_W     = 9;
   localparam int B_NMI      = 0;
   localparam int B_SWIN     = 1;
   localparam int B_HNDOUT   = 2;
   localparam int B_TMO      = 3;
   localparam int B_RSVD_LO  = 4;
   localparam int B_RSVD_HI  = 6;
   localparam int B_CENT     = 7;
   localparam int B_FLASH    = 8;
   localparam int N_PULSE    = 4;
endpackage

// File: rtl/smi_sync_chain.sv
module smi_sync_chain #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("smi_sync_chain: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] shreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shreg <= '0;
      else        shreg <= {shreg[STAGES-2:0], d_i};
   end

   assign q_o = shreg[STAGES-1];
endmodule

// File: rtl/smi_w1c_cell.sv
module smi_w1c_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q_o <= 1'b0;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end

   AST_SET_WINS:  assert property (@(posedge clk) disable iff (!rst_n) set_i |=> q_o);             // R2
   AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (clr_i && !set_i) |=> !q_o); // R1
   AST_W1C_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) (!clr_i && !set_i) |=> $stable(q_o)); // R1
endmodule

// File: rtl/smi_century_track.sv
module smi_century_track #(
   parameter int YEAR_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              rtc_clk,
   input  logic              rtc_rst_n,
   input  logic [YEAR_W-1:0] year_i,
   input  logic              clr_tgl_i,
   output logic              flag_o
);
   generate
      if (YEAR_W != 8) begin : g_bad_year
         $error("smi_century_track: YEAR_W must be 8 for a two-digit BCD year");
      end
   endgenerate

   localparam logic [YEAR_W-1:0] LAST_YEAR  = YEAR_W'(8'h99);
   localparam logic [YEAR_W-1:0] FIRST_YEAR = YEAR_W'(8'h00);

   logic [YEAR_W-1:0] year_q;
   logic              tgl_s, tgl_q, clr_edge, roll;

   smi_sync_chain #(.STAGES(SYNC_STAGES)) u_clr_sync (
      .clk   (rtc_clk),
      .rst_n (rtc_rst_n),
      .d_i   (clr_tgl_i),
      .q_o   (tgl_s)
   );

   assign clr_edge = tgl_s ^ tgl_q;
   assign roll     = (year_q == LAST_YEAR) && (year_i == FIRST_YEAR);

   always_ff @(posedge rtc_clk or negedge rtc_rst_n) begin
      if (!rtc_rst_n) begin
         year_q <= '0;
         tgl_q  <= 1'b0;
         flag_o <= 1'b0;
      end else begin
         year_q <= year_i;
         tgl_q  <= tgl_s;
         if (roll)          flag_o <= 1'b1;
         else if (clr_edge) flag_o <= 1'b0;
      end
   end

   AST_ROLL_SETS:  assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n) roll |=> flag_o);                  // R5
   AST_CENT_CLEAR: assert property (@(posedge rtc_clk) disable iff (!rtc_rst_n) (clr_edge && !roll) |=> !flag_o);  // R6
endmodule

// File: rtl/smi_evt_status.sv
module smi_evt_status
   import smi_stat_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int YEAR_W      = 8,
   parameter bit HAS_CENTURY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [STAT_W-1:0] reg_wdata,
   input  logic              prot_en,
   input  logic              prot_lock,
   input  logic              flash_wr,
   input  logic              flash_low_alias,
   input  logic              rtc_clk,
   input  logic              rtc_rst_n,
   input  logic [YEAR_W-1:0] year_bcd,
   input  logic              wdog_expire,
   input  logic              hnd_out_wr,
   input  logic              sw_in_wr,
   input  logic              nmi_redir_en,
   input  logic              nmi_pending,
   output logic [STAT_W-1:0] status,
   output logic              smi_req_n
);
   localparam int PULSE_POS [N_PULSE] = '{B_FLASH, B_TMO, B_HNDOUT, B_SWIN};

   logic               prot_q, flash_set, nmi_q, cent_rd;
   logic [N_PULSE-1:0] pulse_set, pulse_q;
   logic               unused_wdata;

   assign unused_wdata = ^{reg_wdata[B_RSVD_HI:B_RSVD_LO], reg_wdata[B_NMI]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prot_q <= 1'b0;
      else        prot_q <= prot_en;
   end

   assign flash_set = (prot_en && !prot_q && prot_lock) ||
                      (flash_wr && prot_en && !flash_low_alias);

   assign pulse_set = {sw_in_wr, hnd_out_wr, wdog_expire, flash_set};

   generate
      for (genvar g = 0; g < N_PULSE; g++) begin : g_pulse
         smi_w1c_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (pulse_set[g]),
            .clr_i (reg_wr && reg_wdata[PULSE_POS[g]]),
            .q_o   (pulse_q[g])
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) nmi_q <= 1'b0;
      else        nmi_q <= nmi_pending && (nmi_q || nmi_redir_en);
   end

   generate
      if (HAS_CENTURY) begin : g_century
         logic clr_tgl, flag_slow;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                            clr_tgl <= 1'b0;
            else if (reg_wr && reg_wdata[B_CENT])  clr_tgl <= ~clr_tgl;
         end

         smi_century_track #(.YEAR_W(YEAR_W), .SYNC_STAGES(SYNC_STAGES)) u_track (
            .rtc_clk   (rtc_clk),
            .rtc_rst_n (rtc_rst_n),
            .year_i    (year_bcd),
            .clr_tgl_i (clr_tgl),
            .flag_o    (flag_slow)
         );

         smi_sync_chain #(.STAGES(SYNC_STAGES)) u_back_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (flag_slow),
            .q_o   (cent_rd)
         );
      end else begin : g_no_century
         assign cent_rd = 1'b0;
      end
   endgenerate

   always_comb begin
      status = '0;
      for (int i = 0; i < N_PULSE; i++) status[PULSE_POS[i]] = pulse_q[i];
      status[B_CENT] = cent_rd;
      status[B_NMI]  = nmi_q;
   end

   assign smi_req_n = ~|status;

   AST_NMI_DROP:    assert property (@(posedge clk) disable iff (!rst_n) !nmi_pending |=> !status[B_NMI]);                    // R9
   AST_NMI_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) (nmi_pending && nmi_redir_en) |=> status[B_NMI]);   // R9
   AST_FLASH_PROT:  assert property (@(posedge clk) disable iff (!rst_n) (flash_wr && prot_en && !flash_low_alias) |=> status[B_FLASH]); // R3
   AST_LOCK_RISE:   assert property (@(posedge clk) disable iff (!rst_n) ($rose(prot_en) && prot_lock) |=> status[B_FLASH]); // R4
   AST_TMO_SET:     assert property (@(posedge clk) disable iff (!rst_n) wdog_expire |=> (status[B_TMO] && !smi_req_n));   // R8
endmodule

// File: tb/tb_smi_evt_status.sv
module tb_smi_evt_status;
   logic       clk = 1'b0, rtc_clk = 1'b0;
   logic       rst_n = 1'b0, rtc_rst_n = 1'b0;
   logic       reg_wr = 1'b0;
   logic [8:0] reg_wdata = '0;
   logic       prot_en = 1'b0, prot_lock = 1'b0, flash_wr = 1'b0, flash_low_alias = 1'b0;
   logic [7:0] year_bcd = '0;
   logic       wdog_expire = 1'b0, hnd_out_wr = 1'b0, sw_in_wr = 1'b0;
   logic       nmi_redir_en = 1'b0, nmi_pending = 1'b0;
   logic [8:0] status;
   logic       smi_req_n;

   int vectors = 0;
   int miscompares = 0;

   always #5  clk = ~clk;
   always #15 rtc_clk = ~rtc_clk;

   smi_evt_status dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .prot_en(prot_en), .prot_lock(prot_lock), .flash_wr(flash_wr),
      .flash_low_alias(flash_low_alias), .rtc_clk(rtc_clk), .rtc_rst_n(rtc_rst_n),
      .year_bcd(year_bcd), .wdog_expire(wdog_expire), .hnd_out_wr(hnd_out_wr),
      .sw_in_wr(sw_in_wr), .nmi_redir_en(nmi_redir_en), .nmi_pending(nmi_pending),
      .status(status), .smi_req_n(smi_req_n)
   );

   task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr(input logic [8:0] d);
      reg_wr = 1'b1; reg_wdata = d;
      step();
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic ystep(input logic [7:0] y);
      @(negedge rtc_clk); year_bcd = y;
      @(negedge rtc_clk);
   endtask

   task automatic settle();
      repeat (10) step();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      vectors++; miscompares++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (4) step();
      rst_n = 1'b1; rtc_rst_n = 1'b1;
      step();
      chk("R12 status", status, 9'h000);
      chk("R12 smi", {8'h0, smi_req_n}, 9'h001);

      // R8, R1, R11: each mailbox / watchdog pulse bit
      for (int k = 0; k < 3; k++) begin
         int pos;
         pos = (k == 0) ? 3 : (k == 1) ? 2 : 1;
         case (k)
            0: wdog_expire = 1'b1;
            1: hnd_out_wr  = 1'b1;
            default: sw_in_wr = 1'b1;
         endcase
         step();
         wdog_expire = 1'b0; hnd_out_wr = 1'b0; sw_in_wr = 1'b0;
         chk("R8 pulse sets bit", status, 9'(1 << pos));
         chk("R11 smi asserted", {8'h0, smi_req_n}, 9'h000);
         wr(9'h1FF & ~9'(1 << pos));
         chk("R1 zero write keeps bit", status, 9'(1 << pos));
         wr(9'(1 << pos));
         chk("R1 one write clears", status, 9'h000);
         chk("R11 smi released", {8'h0, smi_req_n}, 9'h001);
      end

      // R2: set and clear together
      wdog_expire = 1'b1; reg_wr = 1'b1; reg_wdata = 9'h008;
      step();
      wdog_expire = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
      chk("R2 set beats clear", status, 9'h008);
      wr(9'h008);

      // R3: flash write under every protect/alias combination (lock off)
      for (int pe = 0; pe < 2; pe++) begin
         for (int al = 0; al < 2; al++) begin
            prot_en = pe[0];
            step();
            chk("R4 rise without lock", status, 9'h000);
            flash_wr = 1'b1; flash_low_alias = al[0];
            step();
            flash_wr = 1'b0; flash_low_alias = 1'b0;
            chk("R3 flash write", status, (pe == 1 && al == 0) ? 9'h100 : 9'h000);
            wr(9'h100);
            prot_en = 1'b0;
            step();
         end
      end

      // R4: protect-enable rising edge under lock
      for (int lk = 0; lk < 2; lk++) begin
         prot_lock = lk[0]; prot_en = 1'b0;
         step();
         prot_en = 1'b1;
         step();
         chk("R4 rise with lock", status, lk[0] ? 9'h100 : 9'h000);
         wr(9'h100);
         repeat (2) step();
         chk("R4 held enable quiet", status, 9'h000);
         prot_en = 1'b0; prot_lock = 1'b0;
         step();
      end

      // R9: NMI redirect mirror
      nmi_redir_en = 1'b1; nmi_pending = 1'b1;
      step();
      chk("R9 nmi captured", status, 9'h001);
      nmi_redir_en = 1'b0;
      step();
      chk("R9 nmi held", status, 9'h001);
      wr(9'h001);
      chk("R9 write ignored", status, 9'h001);
      nmi_pending = 1'b0;
      step();
      chk("R9 nmi follows source", status, 9'h000);
      nmi_pending = 1'b1;
      step();
      chk("R9 no capture when disabled", status, 9'h000);
      nmi_pending = 1'b0;
      step();

      // R10: reserved bits
      wr(9'h070);
      chk("R10 reserved write", status, 9'h000);
      wdog_expire = 1'b1;
      step();
      wdog_expire = 1'b0;
      wr(9'h070);
      chk("R10 reserved write with bit set", status, 9'h008);
      wr(9'h008);

      // R5: full BCD sweep 00..99, then wrap
      for (int i = 0; i < 100; i++) ystep(8'(((i / 10) << 4) | (i % 10)));
      settle();
      chk("R5 sweep without wrap", status, 9'h000);
      ystep(8'h00);
      settle();
      chk("R5 wrap sets century", status, 9'h080);
      chk("R11 smi on century", {8'h0, smi_req_n}, 9'h000);

      // R6: delayed clear across domains
      wr(9'h080);
      chk("R6 still reads set", status, 9'h080);
      repeat (20) step();
      chk("R6 clear completes", status, 9'h000);

      // R7: slow-domain reset
      ystep(8'h99);
      ystep(8'h00);
      settle();
      chk("R7 century set again", status, 9'h080);
      @(negedge rtc_clk); rtc_rst_n = 1'b0;
      @(negedge rtc_clk); rtc_rst_n = 1'b1;
      settle();
      chk("R7 slow reset clears", status, 9'h000);
      chk("R11 smi idle at end", {8'h0, smi_req_n}, 9'h001);

      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule